// File: doc/BRIEF.md
# Palette Pixel Path with Display Mode Select

This block turns a stream of packed 32-bit frame-buffer words into a stream of 12-bit colour values (4 bits each of red, green and blue). Each word is split into pixels, lowest pixel first. Low-depth pixels (4 or 8 bits) index a 256-entry colour palette. High-colour pixels (each in a 16-bit container) are reduced straight to 4:4:4 without the palette.

A display select bit chooses where each colour goes. In passive mode the result is offered on a dither-side handshake. In active mode it bypasses dither and is offered on the output handshake. The pixel format and the display select are sampled only on a start-of-frame strobe, so one frame never mixes formats. A single register stage holds each colour under backpressure. The unpacker moves to the next pixel only when that stage takes the current one.

Top module: `pal_pixel_path`

## Requirements
- R1: While reset is held, and after it is released with no input, `out_valid` and `dth_valid` are 0 and `in_ready` is 1.
- R2: Pixels leave a word lowest-bits first. A word carries 8, 4 or 2 pixels for format code 0 (4-bit), 1 (8-bit), and 2 or 3 (16-bit container).
- R3: In format 0, pixel bits [3:0] address palette entries 0 to 15. Entries above 15 are never used.
- R4: Asserting `pal_we` stores `pal_wdata` into entry `pal_waddr` at the clock edge. In format 1, the pixel byte selects the entry whose colour is emitted.
- R5: In format 2, container bits [15:12], [10:7] and [4:1] become colour bits [11:8], [7:4] and [3:0].
- R6: In format 3, the colour equals container bits [11:0].
- R7: With the display select at 0, colours appear only on the dither port. With it at 1, colours appear only on the output port. The unused port's valid stays 0.
- R8: A presented colour with its ready low stays valid, with unchanged value, in the next cycle.
- R9: A new word is taken only once the last pixel of the held word has been taken. With a sink that is always ready and a continuous input, one colour is emitted in every cycle.
- R10: `cfg_fmt` and `cfg_active` take effect only in a cycle where `sof` is 1. Changes at other times have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Start-of-frame strobe; samples the configuration |
| cfg_fmt | input | 2 | Pixel format code (0: 4-bit, 1: 8-bit, 2: 5:6:5, 3: 12-bit in 16) |
| cfg_active | input | 1 | Display select: 0 passive (dither port), 1 active (output port) |
| pal_we | input | 1 | Palette write enable |
| pal_waddr | input | 8 | Palette write entry |
| pal_wdata | input | 12 | Palette write colour |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Packed frame-buffer word |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| out_valid | output | 1 | Active-mode colour valid |
| out_ready | input | 1 | Active-mode sink ready |
| out_rgb | output | 12 | Active-mode colour, red in [11:8] |
| dth_valid | output | 1 | Passive-mode colour valid toward dither |
| dth_ready | input | 1 | Dither sink ready |
| dth_rgb | output | 12 | Passive-mode colour, red in [11:8] |

## Verification
The last-pixel handoff of a held word and the intake of the next word can happen in the same cycle. The bench provokes this by streaming 16-bit words with a continuous valid into a sink that is always ready. It judges the result by requiring eight colours on eight consecutive cycles, in order. Random sink stalls then drive the same handoff under backpressure. Each colour is compared against a bench model of the palette and the unpacking order.

// File: rtl/pal_pkg.sv
package pal_pkg;

   typedef enum logic [1:0] {
      FMT_P4   = 2'd0,
      FMT_P8   = 2'd1,
      FMT_HC16 = 2'd2,
      FMT_HC12 = 2'd3
   } pix_fmt_e;

   localparam int RGB_W = 12;
   localparam int CONT_W = 16;

   // 5:6:5 container reduced to the top four bits of each channel
   function automatic logic [RGB_W-1:0] hc16_reduce(input logic [CONT_W-1:0] p);
      return {p[15:12], p[10:7], p[4:1]};
   endfunction

endpackage

// File: rtl/pal_unpack.sv
module pal_unpack
   import pal_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  pix_fmt_e                 fmt,
   input  logic                     in_valid,
   input  logic [WORD_W-1:0]        in_data,
   output logic                     in_ready,
   output logic                     pix_valid,
   output logic [CONT_W-1:0]        pix_raw,
   input  logic                     pix_take
);

   localparam int MAX_PPW = WORD_W / 4;
   localparam int CNT_W   = $clog2(MAX_PPW);
   localparam int SH_W    = $clog2(WORD_W);

   initial begin
      assert (WORD_W >= 32 && (WORD_W & (WORD_W - 1)) == 0)
         else $error("pal_unpack: WORD_W must be a power of two, at least 32");
   end

   logic [WORD_W-1:0] word_q;
   logic              have_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  last_cnt;
   logic [SH_W-1:0]   shamt;
   logic [WORD_W-1:0] shifted;
   logic              is_last;

   always_comb begin
      case (fmt)
         FMT_P4: begin
            last_cnt = CNT_W'(MAX_PPW - 1);
            shamt    = {cnt_q, 2'b00};
         end
         FMT_P8: begin
            last_cnt = CNT_W'(MAX_PPW / 2 - 1);
            shamt    = {cnt_q[CNT_W-2:0], 3'b000};
         end
         default: begin
            last_cnt = CNT_W'(MAX_PPW / 4 - 1);
            shamt    = {cnt_q[CNT_W-3:0], 4'b0000};
         end
      endcase
   end

   assign shifted   = word_q >> shamt;
   assign pix_raw   = shifted[CONT_W-1:0];
   assign is_last   = (cnt_q == last_cnt);
   assign pix_valid = have_q;
   assign in_ready  = !have_q || (pix_take && is_last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
         have_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         if (pix_take && !is_last) begin
            cnt_q <= cnt_q + 1'b1;
         end else if (pix_take && is_last) begin
            have_q <= 1'b0;
         end
         if (in_valid && in_ready) begin
            word_q <= in_data;
            have_q <= 1'b1;
            cnt_q  <= '0;
         end
      end
   end

   // R9: the held word and its position stay put until a pixel is taken
   assert_word_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (have_q && !pix_take) |=> ($stable(word_q) && $stable(cnt_q) && have_q));

   // R2: the pixel position never passes the last pixel of the format
   assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      have_q |-> (cnt_q <= last_cnt));

   assert_take_needs_pix_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pix_take |-> have_q);

endmodule

// File: rtl/pal_ram.sv
module pal_ram #(
   parameter int IDX_W  = 8,
   parameter int DEPTH  = 256,
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  raddr,
   output logic [DATA_W-1:0] rdata
);

   initial begin
      assert (DEPTH >= 16 && DEPTH <= (1 << IDX_W))
         else $error("pal_ram: DEPTH must lie between 16 and 2**IDX_W");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   generate
      if (DEPTH == (1 << IDX_W)) begin : g_full
         always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata;
         end
         assign rdata = mem[raddr];
      end else begin : g_part
         always_ff @(posedge clk) begin
            if (we && (int'(waddr) < DEPTH)) mem[waddr] <= wdata;
         end
         assign rdata = (int'(raddr) < DEPTH) ? mem[raddr] : '0;
      end
   endgenerate

endmodule

// File: rtl/pal_colour.sv
module pal_colour
   import pal_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  pix_fmt_e          fmt,
   input  logic [CONT_W-1:0] raw,
   output logic [IDX_W-1:0]  pal_idx,
   input  logic [RGB_W-1:0]  pal_rgb,
   output logic [RGB_W-1:0]  rgb
);

   initial begin
      assert (IDX_W >= 4 && IDX_W <= 8)
         else $error("pal_colour: IDX_W must be 4 to 8");
   end

   always_comb begin
      if (fmt == FMT_P4) pal_idx = IDX_W'(raw[3:0]);
      else               pal_idx = raw[IDX_W-1:0];
   end

   always_comb begin
      case (fmt)
         FMT_P4, FMT_P8: rgb = pal_rgb;
         FMT_HC16:       rgb = hc16_reduce(raw);
         default:        rgb = raw[RGB_W-1:0];
      endcase
   end

endmodule

// File: rtl/pal_out_stage.sv
module pal_out_stage
   import pal_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_sel,
   input  logic             src_valid,
   input  logic [RGB_W-1:0] src_rgb,
   output logic             src_take,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [RGB_W-1:0] out_rgb,
   output logic             dth_valid,
   input  logic             dth_ready,
   output logic [RGB_W-1:0] dth_rgb
);

   logic             res_v;
   logic [RGB_W-1:0] res_q;
   logic             sink_rdy;
   logic             fire;

   assign sink_rdy = act_sel ? out_ready : dth_ready;
   assign fire     = res_v && sink_rdy;
   assign src_take = src_valid && (!res_v || fire);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_v <= 1'b0;
         res_q <= '0;
      end else begin
         if (src_take) begin
            res_v <= 1'b1;
            res_q <= src_rgb;
         end else if (fire) begin
            res_v <= 1'b0;
         end
      end
   end

   assign out_valid = res_v && act_sel;
   assign dth_valid = res_v && !act_sel;
   assign out_rgb   = res_q;
   assign dth_rgb   = res_q;

   // R8: a stalled colour keeps its value and stays valid
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (res_v && !sink_rdy) |=> (res_v && $stable(res_q)));

endmodule

// File: rtl/pal_pixel_path.sv
module pal_pixel_path
   import pal_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int IDX_W     = 8,
   parameter int PAL_DEPTH = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sof,
   input  logic [1:0]        cfg_fmt,
   input  logic              cfg_active,
   input  logic              pal_we,
   input  logic [IDX_W-1:0]  pal_waddr,
   input  logic [RGB_W-1:0]  pal_wdata,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_data,
   output logic              in_ready,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [RGB_W-1:0]  out_rgb,
   output logic              dth_valid,
   input  logic              dth_ready,
   output logic [RGB_W-1:0]  dth_rgb
);

   pix_fmt_e          fmt_q;
   logic              act_q;
   logic              pix_valid;
   logic [CONT_W-1:0] pix_raw;
   logic              pix_take;
   logic [IDX_W-1:0]  pal_idx;
   logic [RGB_W-1:0]  pal_rgb;
   logic [RGB_W-1:0]  pix_rgb;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fmt_q <= FMT_P4;
         act_q <= 1'b0;
      end else if (sof) begin
         fmt_q <= pix_fmt_e'(cfg_fmt);
         act_q <= cfg_active;
      end
   end

   pal_unpack #(.WORD_W(WORD_W)) u_unpack (
      .clk(clk), .rst_n(rst_n), .fmt(fmt_q),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .pix_valid(pix_valid), .pix_raw(pix_raw), .pix_take(pix_take)
   );

   pal_ram #(.IDX_W(IDX_W), .DEPTH(PAL_DEPTH), .DATA_W(RGB_W)) u_ram (
      .clk(clk), .we(pal_we), .waddr(pal_waddr), .wdata(pal_wdata),
      .raddr(pal_idx), .rdata(pal_rgb)
   );

   pal_colour #(.IDX_W(IDX_W)) u_colour (
      .fmt(fmt_q), .raw(pix_raw), .pal_idx(pal_idx),
      .pal_rgb(pal_rgb), .rgb(pix_rgb)
   );

   pal_out_stage u_out (
      .clk(clk), .rst_n(rst_n), .act_sel(act_q),
      .src_valid(pix_valid), .src_rgb(pix_rgb), .src_take(pix_take),
      .out_valid(out_valid), .out_ready(out_ready), .out_rgb(out_rgb),
      .dth_valid(dth_valid), .dth_ready(dth_ready), .dth_rgb(dth_rgb)
   );

   // R10: configuration only moves on a start-of-frame strobe
   assert_cfg_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !sof |=> ($stable(fmt_q) && $stable(act_q)));

   // R7: at most one of the two sinks sees a valid colour
   assert_one_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({out_valid, dth_valid}));

   // R1: nothing is presented in the cycle after reset
   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && !dth_valid));

endmodule

// File: tb/pal_pixel_path_bench.sv
module pal_pixel_path_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sof = 1'b0;
   logic [1:0]  cfg_fmt = 2'd0;
   logic        cfg_active = 1'b0;
   logic        pal_we = 1'b0;
   logic [7:0]  pal_waddr = '0;
   logic [11:0] pal_wdata = '0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        in_ready;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [11:0] out_rgb;
   logic        dth_valid;
   logic        dth_ready = 1'b0;
   logic [11:0] dth_rgb;

   int checks = 0;
   int fails = 0;

   logic [11:0] pal_m [256];
   logic [11:0] exp_q [$];
   logic [1:0]  expf_q [$];
   logic [1:0]  cur_fmt = 2'd0;
   logic        cur_act = 1'b0;
   logic        ready_all = 1'b0;
   logic        hold_pend = 1'b0;
   logic [11:0] hold_val = '0;
   int          cyc = 0;
   int          track = 0;
   int          first_cyc = 0;
   int          last_cyc = 0;
   int          fire_n = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pal_pixel_path u_pal_pixel_path (
      .clk(clk), .rst_n(rst_n), .sof(sof), .cfg_fmt(cfg_fmt),
      .cfg_active(cfg_active), .pal_we(pal_we), .pal_waddr(pal_waddr),
      .pal_wdata(pal_wdata), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
      .out_rgb(out_rgb), .dth_valid(dth_valid), .dth_ready(dth_ready),
      .dth_rgb(dth_rgb)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int ppw(input logic [1:0] f);
      return (f == 2'd0) ? 8 : (f == 2'd1) ? 4 : 2;
   endfunction

   function automatic logic [11:0] exp_pix(input logic [31:0] w, input logic [1:0] f, input int k);
      logic [15:0] p;
      case (f)
         2'd0: return pal_m[{4'h0, w[4*k +: 4]}];
         2'd1: return pal_m[w[8*k +: 8]];
         2'd2: begin p = w[16*k +: 16]; return {p[15:12], p[10:7], p[4:1]}; end
         default: begin p = w[16*k +: 16]; return p[11:0]; end
      endcase
   endfunction

   function automatic string tag(input logic [1:0] f);
      case (f)
         2'd0: return "R2/R3";
         2'd1: return "R2/R4";
         2'd2: return "R5";
         default: return "R6";
      endcase
   endfunction

   // sink side: drive readiness, then judge what is presented
   always @(negedge clk) begin
      logic vv, oth, rdy;
      logic [11:0] got, e;
      logic [1:0] ef;
      cyc++;
      if (rst_n) begin
         rdy = ready_all ? 1'b1 : (($urandom % 4) != 0);
         out_ready = cur_act ? rdy : ($urandom % 2 == 1);
         dth_ready = cur_act ? ($urandom % 2 == 1) : rdy;
         #1;
         vv  = cur_act ? out_valid : dth_valid;
         oth = cur_act ? dth_valid : out_valid;
         got = cur_act ? out_rgb : dth_rgb;
         if (hold_pend)
            check(vv && got == hold_val, "R8", {19'd0, vv, got}, {20'h00001, hold_val});
         if (oth) check(1'b0, "R7/R10", 32'd1, 32'd0);
         if (vv && rdy) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R9", {20'd0, got}, 32'hFFFFFFFF);
            end else begin
               e = exp_q.pop_front();
               ef = expf_q.pop_front();
               check(got == e, tag(ef), {20'd0, got}, {20'd0, e});
               if (track != 0) begin
                  if (fire_n == 0) first_cyc = cyc;
                  last_cyc = cyc;
                  fire_n++;
               end
            end
         end
         hold_pend = vv && !rdy;
         hold_val = got;
      end
   end

   task automatic send_word(input logic [31:0] w);
      for (int k = 0; k < ppw(cur_fmt); k++) begin
         exp_q.push_back(exp_pix(w, cur_fmt, k));
         expf_q.push_back(cur_fmt);
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_data = w;
      forever begin
         #2;
         if (in_ready) break;
         @(negedge clk);
      end
      @(posedge clk);
   endtask

   task automatic idle_input();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic write_pal(input logic [7:0] a, input logic [11:0] d);
      @(negedge clk);
      pal_we = 1'b1; pal_waddr = a; pal_wdata = d;
      @(negedge clk);
      pal_we = 1'b0;
      pal_m[a] = d;
   endtask

   // new frame; afterwards the config pins wander without a strobe (R10)
   task automatic frame(input logic [1:0] f, input logic a);
      drain();
      @(negedge clk);
      cfg_fmt = f; cfg_active = a; sof = 1'b1;
      @(negedge clk);
      sof = 1'b0;
      cur_fmt = f; cur_act = a;
      cfg_fmt = ~f; cfg_active = ~a;
   endtask

   initial begin
      int cnt;
      void'($urandom(32'd2024));
      forever begin
         @(posedge clk);
         cnt++;
         if (cnt > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected<150000", cnt);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
         end
      end
   end

   initial begin
      // R1: idle during and after reset
      repeat (3) @(negedge clk);
      #1;
      check(!out_valid && !dth_valid, "R1", {out_valid, dth_valid}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      check(!out_valid && !dth_valid, "R1", {out_valid, dth_valid}, 0);
      check(in_ready == 1'b1, "R1", in_ready, 1);

      for (int i = 0; i < 256; i++) write_pal(i[7:0], 12'($urandom));

      // R3: nibble F reaches entry 15, never 255
      frame(2'd0, 1'b0);
      send_word(32'hF0FF_1E2F);
      send_word(32'h7654_3210);
      idle_input();

      // R4: reprogram entries, then byte index 0xFF and 0x00
      drain();
      write_pal(8'hFF, 12'hA5C);
      write_pal(8'h00, 12'h3C1);
      frame(2'd1, 1'b1);
      send_word(32'h00FF_FF00);
      idle_input();

      // R5, R6 directed containers
      frame(2'd2, 1'b1);
      send_word(32'hFFFF_0000);
      send_word(32'h8421_F81F);
      idle_input();
      frame(2'd3, 1'b0);
      send_word(32'hFABC_0123);
      idle_input();

      // R9: last-pixel handoff and next word intake in one cycle
      frame(2'd2, 1'b0);
      ready_all = 1'b1;
      @(negedge clk);
      track = 1; fire_n = 0;
      for (int i = 0; i < 4; i++) send_word($urandom);
      idle_input();
      drain();
      track = 0;
      check(fire_n == 8 && (last_cyc - first_cyc) == 7, "R9",
            last_cyc - first_cyc, 7);
      ready_all = 1'b0;

      // random frames with stalls and gaps
      for (int fr = 0; fr < 24; fr++) begin
         if (fr % 6 == 5) begin
            drain();
            for (int j = 0; j < 4; j++) write_pal(8'($urandom), 12'($urandom));
         end
         frame(2'($urandom), 1'($urandom));
         for (int wd = 0; wd < 6; wd++) begin
            send_word($urandom);
            if ($urandom % 3 == 0) idle_input();
         end
         idle_input();
      end
      drain();

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule